// File: doc/BRIEF.md
# Transmit Deferral Gate

This block keeps a serial transmitter from starting while software is still filling its transmit FIFO through programmed I/O. Each time the transmitter runs dry, the block closes a gate. The transmitter then waits, and software can queue a burst of bytes without the shift register starving partway through a frame.

The gate opens again in either of two cases. The first is that the FIFO fill level reaches a threshold that depends on the configured FIFO depth. The second is that software stops writing for a fixed number of microsecond ticks. Every FIFO write restarts that quiet-time count. Deferral takes effect only when three configuration flags are set together: the extended operating mode, the FIFO enable and the deferral enable. The transmitter and the FIFO sit outside this block. The block watches the FIFO level, the write strobe and the transmitter idle flag.

Top module: `tdl_gate`

## Requirements
- R1: After reset the gate is open (`tx_go_o` = 1). The idle history is taken as idle, so a transmitter that is already idle at reset does not close the gate.
- R2: Deferral is armed only while `defer_en_i`, `ext_mode_i` and `fifo_en_i` are all 1. If any of them is 0 at a clock edge, the gate is open after that edge, and a rise of `tx_idle_i` does not close it.
- R3: When armed and open, a rise of `tx_idle_i` closes the gate at that clock edge (`tx_go_o` = 0 after it). A rise means 0 in the previous cycle and 1 in this cycle.
- R4: While closed, the gate opens at the edge where `fifo_level_i` is at least 14 with `depth32_i` = 0, or at least 30 with `depth32_i` = 1. Levels of 13 and 29 respectively keep it closed.
- R5: While closed with `fifo_level_i` ≥ 1, the gate opens at the edge that samples the 64th `us_tick_i` pulse counted since the last reload.
- R6: A `fifo_wr_i` pulse while closed reloads the quiet-time count to 64 ticks. A tick in the same cycle as a write is not counted.
- R7: Ticks that arrive while `fifo_level_i` = 0 are not counted, and the count restarts from 64 once the FIFO holds data.
- R8: After the gate opens, it closes again only on a new rise of `tx_idle_i`. An idle level that stays at 1 does not close it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | One-cycle pulse, once per microsecond |
| defer_en_i | input | 1 | Deferral enable |
| ext_mode_i | input | 1 | Extended operating mode flag |
| fifo_en_i | input | 1 | Transmit FIFO enabled flag |
| depth32_i | input | 1 | FIFO depth select: 0 = 16 entries, 1 = 32 entries |
| fifo_level_i | input | LVL_W (6) | Current transmit FIFO occupancy |
| fifo_wr_i | input | 1 | FIFO write strobe, one pulse per byte |
| tx_idle_i | input | 1 | Transmitter empty flag |
| tx_go_o | output | 1 | 1 = transmitter may start sending |

## Verification
A lock flag stuck at 1 holds `tx_go_o` low for good, and a transmitter connected to it never sends. A lock flag stuck at 0 lets the transmitter start on the first byte. Either fault shows at the port one cycle after the triggering idle rise or fill edge. A fault in the quiet-time counter is less direct: it moves the release edge away from the 64th tick, or it leaves the gate closed when it should open. The bench counts the ticks exactly. An off-by-one count, a missed reload or a count that runs while the FIFO is empty therefore shows as a release one tick early or one tick late.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

    // Default geometry of the deferral gate
    localparam int unsigned TDL_LVL_W      = 6;
    localparam int unsigned TDL_THR_SMALL  = 14;
    localparam int unsigned TDL_THR_LARGE  = 30;
    localparam int unsigned TDL_QUIET_US   = 64;

    // Registered state of the gate itself
    typedef struct packed {
        logic lock;
    } tdl_gate_state_t;

endpackage

// File: rtl/tdl_edge.sv
// Rise detector on the transmitter-empty flag; history resets to "idle".
module tdl_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic rise_o
);

    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
        rise_o    = lvl_i & ~st_q.prev;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tdl_fill_cmp.sv
// Fill-level comparator; threshold picked by the depth select.
module tdl_fill_cmp #(
    parameter int unsigned LVL_W     = 6,
    parameter int unsigned THR_SMALL = 14,
    parameter int unsigned THR_LARGE = 30
) (
    input  logic             depth32_i,
    input  logic [LVL_W-1:0] level_i,
    output logic             full_o
);

    localparam logic [LVL_W-1:0] ThrS = LVL_W'(THR_SMALL);
    localparam logic [LVL_W-1:0] ThrL = LVL_W'(THR_LARGE);

    logic [LVL_W-1:0] thr;

    always_comb begin
        thr    = depth32_i ? ThrL : ThrS;
        full_o = (level_i >= thr);
    end

endmodule

// File: rtl/tdl_timer.sv
// Quiet-time counter in microsecond ticks, reloaded on load or when idle.
module tdl_timer #(
    parameter int unsigned RELOAD = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic load_i,
    input  logic tick_i,
    output logic expire_o
);

    localparam int unsigned CNT_W = $clog2(RELOAD + 1);
    localparam logic [CNT_W-1:0] CntInit = CNT_W'(RELOAD);
    localparam logic [CNT_W-1:0] CntLast = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (!run_i || load_i) begin
            st_d.cnt = CntInit;
        end else if (tick_i) begin
            if (st_q.cnt == CntLast) begin
                expire_o = 1'b1;
                st_d.cnt = CntInit;
            end else begin
                st_d.cnt = st_q.cnt - CntLast;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt <= CntInit;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tdl_gate.sv
// Transmit deferral gate: top level.
module tdl_gate #(
    parameter int unsigned LVL_W     = tdl_pkg::TDL_LVL_W,
    parameter int unsigned THR_SMALL = tdl_pkg::TDL_THR_SMALL,
    parameter int unsigned THR_LARGE = tdl_pkg::TDL_THR_LARGE,
    parameter int unsigned QUIET_US  = tdl_pkg::TDL_QUIET_US
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             us_tick_i,
    input  logic             defer_en_i,
    input  logic             ext_mode_i,
    input  logic             fifo_en_i,
    input  logic             depth32_i,
    input  logic [LVL_W-1:0] fifo_level_i,
    input  logic             fifo_wr_i,
    input  logic             tx_idle_i,
    output logic             tx_go_o
);

    import tdl_pkg::*;

    tdl_gate_state_t st_d, st_q;

    logic armed;
    logic idle_rise;
    logic fill_hit;
    logic quiet_exp;
    logic tmr_run;

    tdl_edge u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (tx_idle_i),
        .rise_o (idle_rise)
    );

    tdl_fill_cmp #(
        .LVL_W     (LVL_W),
        .THR_SMALL (THR_SMALL),
        .THR_LARGE (THR_LARGE)
    ) u_fill (
        .depth32_i (depth32_i),
        .level_i   (fifo_level_i),
        .full_o    (fill_hit)
    );

    assign tmr_run = st_q.lock & (fifo_level_i != '0);

    tdl_timer #(
        .RELOAD (QUIET_US)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (tmr_run),
        .load_i   (fifo_wr_i),
        .tick_i   (us_tick_i),
        .expire_o (quiet_exp)
    );

    always_comb begin
        armed = defer_en_i & ext_mode_i & fifo_en_i;
        st_d  = st_q;
        if (!armed) begin
            st_d.lock = 1'b0;
        end else if (st_q.lock) begin
            if (fill_hit || quiet_exp) begin
                st_d.lock = 1'b0;
            end
        end else if (idle_rise) begin
            st_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.lock <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_go_o = ~st_q.lock;

endmodule

// File: rtl/tdl_gate_chk.sv
// Port-level properties of the deferral gate.
module tdl_gate_chk #(
    parameter int unsigned LVL_W     = 6,
    parameter int unsigned THR_SMALL = 14,
    parameter int unsigned THR_LARGE = 30
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             defer_en_i,
    input logic             ext_mode_i,
    input logic             fifo_en_i,
    input logic             depth32_i,
    input logic [LVL_W-1:0] fifo_level_i,
    input logic             tx_idle_i,
    input logic             tx_go_o
);

    logic             arm;
    logic             rise;
    logic             idle_prev;
    logic [LVL_W-1:0] thr;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) idle_prev <= 1'b1;
        else         idle_prev <= tx_idle_i;
    end

    always_comb begin
        arm  = defer_en_i & ext_mode_i & fifo_en_i;
        rise = tx_idle_i & ~idle_prev;
        thr  = depth32_i ? LVL_W'(THR_LARGE) : LVL_W'(THR_SMALL);
    end

    // R1: the gate is open coming out of reset
    always_ff @(posedge clk_i) begin
        if (rst_ni && !$past(rst_ni)) begin
            a_r1_open_after_reset: assert (tx_go_o);
        end
    end

    // R2
    a_r2_disarm_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !arm |=> tx_go_o);

    // R3
    a_r3_rise_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm && tx_go_o && rise) |=> !tx_go_o);

    // R4
    a_r4_fill_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tx_go_o && fifo_level_i >= thr) |=> tx_go_o);

    // R7: an empty FIFO never lets the quiet timer open the gate
    a_r7_empty_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm && !tx_go_o && fifo_level_i == '0) |=> !tx_go_o);

    // R8
    a_r8_no_close_without_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_go_o && !(arm && rise)) |=> tx_go_o);

endmodule

bind tdl_gate tdl_gate_chk #(
    .LVL_W     (LVL_W),
    .THR_SMALL (THR_SMALL),
    .THR_LARGE (THR_LARGE)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .defer_en_i   (defer_en_i),
    .ext_mode_i   (ext_mode_i),
    .fifo_en_i    (fifo_en_i),
    .depth32_i    (depth32_i),
    .fifo_level_i (fifo_level_i),
    .tx_idle_i    (tx_idle_i),
    .tx_go_o      (tx_go_o)
);

// File: tb/tdl_gate_tb.sv
module tdl_gate_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    // Vector fields: [17:14] req tag, [13] defer, [12] ext, [11] fifo_en,
    // [10] depth32, [9:4] level, [3] wr, [2] idle, [1] tick, [0] expected tx_go
    localparam logic [17:0] VEC [NVEC] = '{
        {4'd8, 1'b1,1'b1,1'b1,1'b0, 6'd0,  1'b0,1'b1,1'b0, 1'b1}, // R8 idle held from reset
        {4'd3, 1'b1,1'b1,1'b1,1'b0, 6'd0,  1'b0,1'b0,1'b0, 1'b1}, // R3 idle falls
        {4'd3, 1'b1,1'b1,1'b1,1'b0, 6'd0,  1'b0,1'b1,1'b0, 1'b0}, // R3 rise closes
        {4'd4, 1'b1,1'b1,1'b1,1'b0, 6'd5,  1'b1,1'b1,1'b0, 1'b0}, // R4 below threshold
        {4'd4, 1'b1,1'b1,1'b1,1'b0, 6'd13, 1'b1,1'b1,1'b0, 1'b0}, // R4 13 of 16
        {4'd4, 1'b1,1'b1,1'b1,1'b0, 6'd14, 1'b1,1'b1,1'b0, 1'b1}, // R4 14 opens
        {4'd3, 1'b1,1'b1,1'b1,1'b0, 6'd0,  1'b0,1'b0,1'b0, 1'b1},
        {4'd3, 1'b1,1'b1,1'b1,1'b1, 6'd0,  1'b0,1'b1,1'b0, 1'b0}, // R3 closes, deep fifo
        {4'd4, 1'b1,1'b1,1'b1,1'b1, 6'd14, 1'b1,1'b1,1'b0, 1'b0}, // R4 14 of 32 holds
        {4'd4, 1'b1,1'b1,1'b1,1'b1, 6'd29, 1'b1,1'b1,1'b0, 1'b0}, // R4 29 holds
        {4'd4, 1'b1,1'b1,1'b1,1'b1, 6'd30, 1'b1,1'b1,1'b0, 1'b1}, // R4 30 opens
        {4'd8, 1'b1,1'b1,1'b1,1'b1, 6'd0,  1'b0,1'b1,1'b0, 1'b1}, // R8 stays open
        {4'd3, 1'b1,1'b1,1'b1,1'b0, 6'd0,  1'b0,1'b0,1'b0, 1'b1},
        {4'd3, 1'b1,1'b1,1'b1,1'b0, 6'd0,  1'b0,1'b1,1'b0, 1'b0},
        {4'd2, 1'b0,1'b1,1'b1,1'b0, 6'd0,  1'b0,1'b1,1'b0, 1'b1}, // R2 enable off opens
        {4'd8, 1'b1,1'b1,1'b1,1'b0, 6'd0,  1'b0,1'b1,1'b0, 1'b1}, // R8 re-enable, no rise
        {4'd2, 1'b1,1'b0,1'b1,1'b0, 6'd0,  1'b0,1'b0,1'b0, 1'b1},
        {4'd2, 1'b1,1'b0,1'b1,1'b0, 6'd0,  1'b0,1'b1,1'b0, 1'b1}, // R2 ext off: rise ignored
        {4'd2, 1'b1,1'b1,1'b0,1'b0, 6'd0,  1'b0,1'b0,1'b0, 1'b1},
        {4'd2, 1'b1,1'b1,1'b0,1'b0, 6'd0,  1'b0,1'b1,1'b0, 1'b1}  // R2 fifo off: rise ignored
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       defer_en = 1'b1;
    logic       ext_mode = 1'b1;
    logic       fifo_en = 1'b1;
    logic       depth32 = 1'b0;
    logic [5:0] level = '0;
    logic       wr = 1'b0;
    logic       idle = 1'b1;
    logic       go;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdl_gate u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .us_tick_i    (tick),
        .defer_en_i   (defer_en),
        .ext_mode_i   (ext_mode),
        .fifo_en_i    (fifo_en),
        .depth32_i    (depth32),
        .fifo_level_i (level),
        .fifo_wr_i    (wr),
        .tx_idle_i    (idle),
        .tx_go_o      (go)
    );

    task automatic chk(input string req, input logic exp);
        n_chk++;
        if (go !== exp) begin
            n_fail++;
            $display("FAIL %s: tx_go_o=%b expected %b", req, go, exp);
        end
    endtask

    // Drive one cycle at a negedge, then wait to the next negedge
    task automatic cyc(input logic i_idle, input logic [5:0] i_lvl,
                       input logic i_wr, input logic i_tick);
        idle  = i_idle;
        level = i_lvl;
        wr    = i_wr;
        tick  = i_tick;
        @(negedge clk);
        wr    = 1'b0;
        tick  = 1'b0;
    endtask

    task automatic close_gate();
        cyc(1'b0, 6'd0, 1'b0, 1'b0);
        cyc(1'b1, 6'd0, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 open after reset", 1'b1);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            defer_en = VEC[i][13];
            ext_mode = VEC[i][12];
            fifo_en  = VEC[i][11];
            depth32  = VEC[i][10];
            cyc(VEC[i][2], VEC[i][9:4], VEC[i][3], VEC[i][1]);
            n_chk++;
            if (go !== VEC[i][0]) begin
                n_fail++;
                $display("FAIL R%0d step %0d: tx_go_o=%b expected %b",
                         VEC[i][17:14], i, go, VEC[i][0]);
            end
        end
        defer_en = 1'b1; ext_mode = 1'b1; fifo_en = 1'b1; depth32 = 1'b0;

        // R5: release on the 64th tick
        close_gate();
        chk("R5 closed before ticks", 1'b0);
        cyc(1'b1, 6'd3, 1'b1, 1'b0);
        for (int k = 0; k < 63; k++) cyc(1'b1, 6'd3, 1'b0, 1'b1);
        chk("R5 closed after 63 ticks", 1'b0);
        cyc(1'b1, 6'd3, 1'b0, 1'b1);
        chk("R5 open on 64th tick", 1'b1);

        // R6: a write reloads; a tick with a write is not counted
        close_gate();
        cyc(1'b1, 6'd2, 1'b1, 1'b0);
        for (int k = 0; k < 40; k++) cyc(1'b1, 6'd2, 1'b0, 1'b1);
        cyc(1'b1, 6'd3, 1'b1, 1'b1);
        for (int k = 0; k < 63; k++) cyc(1'b1, 6'd3, 1'b0, 1'b1);
        chk("R6 closed 63 ticks after reload", 1'b0);
        cyc(1'b1, 6'd3, 1'b0, 1'b1);
        chk("R6 open 64 ticks after reload", 1'b1);

        // R7: ticks while empty do not count
        close_gate();
        for (int k = 0; k < 100; k++) cyc(1'b1, 6'd0, 1'b0, 1'b1);
        chk("R7 empty fifo keeps gate closed", 1'b0);
        for (int k = 0; k < 63; k++) cyc(1'b1, 6'd1, 1'b0, 1'b1);
        chk("R7 count restarted from full", 1'b0);
        cyc(1'b1, 6'd1, 1'b0, 1'b1);
        chk("R7 open after 64 counted ticks", 1'b1);

        // R8: stays open while idle holds high
        for (int k = 0; k < 5; k++) cyc(1'b1, 6'd0, 1'b0, 1'b1);
        chk("R8 no relock on held idle", 1'b1);

        // R1: reset while closed reopens the gate
        close_gate();
        chk("R3 closed before reset", 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b1, 6'd0, 1'b0, 1'b0);
        chk("R1 open after mid-run reset", 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule